// File: doc/BRIEF.md
# Fractional Baud Tick Divisor

This block generates the sample-enable pulse for a UART that oversamples each bit sixteen times. Software programs an integer divisor, nominally the input clock divided by sixteen times the baud rate, and a fractional divisor of `FRAC_W` bits. The fractional value is the leftover part of that division, scaled by 2^`FRAC_W` and rounded to nearest. The block emits one `tick` per divided period. Some periods are stretched by one clock so that the mean period equals the integer divisor plus the fraction.

The fraction is added to an `FRAC_W`-bit accumulator once per period. A period whose addition carries out of the accumulator is one clock longer. Over 2^`FRAC_W` consecutive periods, the stretched periods number exactly the fractional value. Both registers can be read back. The fractional register keeps only its implemented bits, so writing all ones and reading the value back shows the implemented width. A fractional value of zero gives plain integer division. An integer divisor of zero stops the ticks.

Top module: `baud_frac_div`

## Requirements
- R1: After reset both divisor registers read as zero and `tick` stays low.
- R2: While the integer divisor is zero, `tick` is never asserted.
- R3: With a fractional value of zero, successive ticks are exactly D clocks apart, where D is the integer divisor.
- R4: With the integer divisor D nonzero, the spacing between consecutive ticks is always D or D+1 clocks.
- R5: After a write, the first 2^FRAC_W tick periods together last exactly D*2^FRAC_W + F clocks, where F is the fractional value.
- R6: A write to either register restarts the period and clears the accumulator. The first tick is then seen in the D-th clock cycle after the write edge.
- R7: Reading the fractional register (`rd_sel`=1) returns the written value masked to its low FRAC_W bits, with all upper bits zero. Writing all ones therefore reads back as 2^FRAC_W-1.
- R8: Reading the integer register (`rd_sel`=0) returns all INT_W bits as written. `wr_sel`=0 selects the integer register and `wr_sel`=1 selects the fractional register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 integer, 1 fraction |
| wr_data | input | INT_W | Write data |
| rd_sel | input | 1 | Read source: 0 integer, 1 fraction |
| rd_data | output | INT_W | Read data (combinational) |
| tick | output | 1 | 16x sample-enable pulse |

## Verification
The assertions check the following on every cycle:
- `tick` stays silent while the integer divisor is zero.
- The spacing between ticks stays within D to D+1 clocks, and is exactly D when the fraction is zero.
- The first tick after any write arrives D cycles after the write edge.
- The fractional read returns no bits above the implemented width.

The exact total over 2^FRAC_W periods is a property of a whole window and depends on the programmed fraction. Only the bench scenarios show it. They run randomized divisor and fraction pairs, a divisor computed from a clock and baud pair, and the divisor-of-one corner where stretched and unstretched periods alternate between one and two clocks.

// File: rtl/baud_frac_div.sv
module baud_frac_div #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [INT_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [INT_W-1:0] rd_data,
  output logic             tick
);
  localparam int CW = INT_W + 1;

  logic [INT_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W-1:0] acc_q;
  logic [CW-1:0]     cnt_q;

  logic [FRAC_W:0]   acc_sum;
  logic              carry;
  logic [CW-1:0]     last;
  logic              run;

  assign acc_sum = {1'b0, acc_q} + {1'b0, frac_q};
  assign carry   = acc_sum[FRAC_W];
  assign run     = div_q != '0;
  assign last    = CW'(div_q) + CW'(carry) - CW'(1);
  assign tick    = run && (cnt_q == last);
  assign rd_data = rd_sel ? INT_W'(frac_q) : div_q;

  wire unused_hi = ^wr_data[INT_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      frac_q <= '0;
      acc_q  <= '0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel) frac_q <= wr_data[FRAC_W-1:0];
      else        div_q  <= wr_data;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
      acc_q <= acc_sum[FRAC_W-1:0];
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/baud_frac_div_chk.sv
module baud_frac_div_chk #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              tick,
  input logic              rd_sel,
  input logic [INT_W-1:0]  rd_data,
  input logic [INT_W-1:0]  div,
  input logic [FRAC_W-1:0] frac
);
  localparam int GW = INT_W + 2;
  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (wr_en) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (tick) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != '1) begin
      gap  <= gap + GW'(1);
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '0) |-> !tick); // R2
  AST_GAP_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (div != '0) |-> (gap <= GW'(div))); // R4
  AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen) |-> (gap >= GW'(div) - GW'(1))); // R4
  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen && frac == '0) |-> (gap == GW'(div) - GW'(1))); // R3
  AST_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !seen) |-> (gap == GW'(div) - GW'(1))); // R6
  AST_FRAC_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |-> (rd_data[INT_W-1:FRAC_W] == '0)); // R7
endmodule

bind baud_frac_div baud_frac_div_chk #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick),
  .rd_sel(rd_sel), .rd_data(rd_data), .div(div_q), .frac(frac_q)
);

// File: tb/baud_frac_div_test.sv
module baud_frac_div_test;
  localparam int INT_W  = 16;
  localparam int FRAC_W = 4;
  localparam int NPER   = 1 << FRAC_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [INT_W-1:0] wr_data = '0;
  logic             rd_sel = 1'b0;
  logic [INT_W-1:0] rd_data;
  logic             tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  baud_frac_div #(.INT_W(INT_W), .FRAC_W(FRAC_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .tick(tick)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic int gold_total(int d, int f);
    return d * NPER + f;
  endfunction

  function automatic int gold_frac(longint clk_hz, longint baud);
    longint base = 16 * baud;
    longint rem  = clk_hz % base;
    return int'(((rem << FRAC_W) + base / 2) / base);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, int val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = INT_W'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_case(int d, int f);
    int cycles = 0, ticks = 0, last = 0, first = 0, out_rng = 0, not_d = 0;
    wr(1'b1, f);
    wr(1'b0, d);
    while (ticks < NPER) begin
      cycles++;
      if (tick) begin
        int len = cycles - last;
        if (ticks == 0) first = len;
        if (len != d && len != d + 1) out_rng++;
        if (len != d) not_d++;
        last = cycles;
        ticks++;
      end
      @(negedge clk);
    end
    check(cycles == gold_total(d, f), "R5 window total", cycles, gold_total(d, f));
    check(out_rng == 0, "R4 spacing out of range", out_rng, 0);
    check(first == d, "R6 first tick after write", first, d);
    if (f == 0) check(not_d == 0, "R3 zero fraction spacing", not_d, 0);
  endtask

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check(tick == 1'b0, "R1 tick after reset", tick, 0);
    rd_sel = 1'b0; #1;
    check(rd_data == 0, "R1 integer after reset", rd_data, 0);
    rd_sel = 1'b1; #1;
    check(rd_data == 0, "R1 fraction after reset", rd_data, 0);
    rst_n = 1'b1;

    seen = 0;
    repeat (50) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R2 idle after reset", seen, 0);

    wr(1'b1, 16'hFFFF);
    rd_sel = 1'b1; #1;
    check(rd_data == NPER - 1, "R7 all-ones readback", rd_data, NPER - 1);
    wr(1'b1, 16'h00A5);
    #1;
    check(rd_data == 16'h0005, "R7 masked readback", rd_data, 5);
    wr(1'b0, 16'hBEEF);
    rd_sel = 1'b0; #1;
    check(rd_data == 16'hBEEF, "R8 integer readback", rd_data, 16'hBEEF);

    run_case(27, gold_frac(50_000_000, 115200));
    run_case(1, 0);
    run_case(1, NPER - 1);
    run_case(2, NPER / 2);
    run_case(5, 0);
    run_case(3, 1);

    process::self().srandom(32'h5EED_0042);
    for (int i = 0; i < 25; i++) begin
      int d = 1 + int'($urandom % 40);
      int f = int'($urandom % NPER);
      run_case(d, f);
    end

    wr(1'b0, 0);
    seen = 0;
    repeat (60) begin @(negedge clk); if (tick) seen++; end
    check(seen == 0, "R2 zero divisor stops ticks", seen, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule